// File: doc/BRIEF.md
# Concatenated Toggle-Group Vertical Clock Generator

This block produces one vertical clock waveform for an image sensor line. A small bank holds several toggle patterns of up to four toggle positions each. Four group slots, A to D, each point at one pattern of the bank. The toggle positions of the four selected patterns are merged into one list of up to sixteen entries. One shared set of timing fields shapes that merged list into the final waveform: start position, polarity, period length and repeat count.

A pixel-count strobe advances the waveform by one position. A line-start pulse rearms it. The output rests at the polarity level until the start position is reached. It then inverts at each merged toggle position, and this repeats for the programmed number of repetitions. A one-cycle done pulse marks the end of the line's waveform.

Several slots may point at the same pattern. Two or three distinct patterns then cover waveforms that need only eight or twelve toggles. A position listed more than once, or lying past the period, toggles nothing extra.

Top module: `vclk_concat_gen`

## Requirements
- R1: Pattern p, slot t (t = 0..3) is the 8-bit field `toggle_bank[(p*4+t)*8 +: 8]`. Pattern p's used-toggle count is `pat_count[p*3 +: 3]`; a count above 4 acts as 4. Group g's pattern pointer is `grp_sel[g*2 +: 2]`, with g = 0 as group A. Each group contributes the first count entries of the pattern it points at.
- R2: The merged toggle set is the union of all four groups' contributions, so up to 16 positions are in effect. At position q of a repetition, `vout` equals `polarity` XOR the parity of the number of merged positions that are less than or equal to q.
- R3: When two or more groups point at the same pattern, that pattern is reused and contributes the same positions again.
- R4: A position that appears more than once in the merged list, within one group or across groups, causes only one inversion.
- R5: A toggle position greater than `period_len` has no effect. A position equal to `period_len` is honoured.
- R6: The line's strobes are numbered from 0, starting with the first `pix_tick` after `line_start`. Strobe number `start_pos` is position 0 of the first repetition. Before it, `vout` equals `polarity`.
- R7: A repetition spans `period_len`+1 positions, and `rep_count`+1 repetitions run back to back. Each repetition begins again from the polarity level at its position 0.
- R8: `done` is high for exactly one cycle, the cycle after the strobe that processes the last position of the last repetition. `vout` keeps that position's level until the next strobe, then returns to `polarity` until the next `line_start`.
- R9: `line_start` takes priority over everything else in its cycle. It restarts the line, sets `vout` to `polarity` in the following cycle, and suppresses `done`. A `pix_tick` in the same cycle is not counted.
- R10: While `rst_n` is low, `vout` and `done` are 0. Outside an active line, `vout` follows `polarity` one cycle later.
- R11: `vout` changes only in the cycle after a `pix_tick` or `line_start`, except outside an active line as stated in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_tick | input | 1 | Pixel-count strobe, advances one position |
| line_start | input | 1 | Line start pulse, rearms the waveform |
| toggle_bank | input | 128 | Pattern bank, 4 patterns x 4 toggle positions x 8 bits |
| pat_count | input | 12 | Used-toggle count per pattern, 3 bits each |
| grp_sel | input | 8 | Pattern pointer for groups A..D, 2 bits each |
| start_pos | input | 8 | Strobe number of the first waveform position |
| polarity | input | 1 | Resting and starting level |
| period_len | input | 8 | Last position of a repetition (period is value+1) |
| rep_count | input | 4 | Number of extra repetitions |
| vout | output | 1 | Vertical clock level |
| done | output | 1 | One-cycle pulse at the end of the waveform |

## Verification
The line-restart function and the position-advance function can land on the same clock edge. The bench drives `line_start` and `pix_tick` in the same cycle in two places: partway through a repetition, and on the strobe that would end the last repetition and raise `done`. In both cases it checks that `vout` returns to `polarity` and that `done` stays low. It then checks that the following strobes number the line from 0, which shows that the coincident strobe was discarded.

// File: rtl/vcg_pkg.sv
`timescale 1ns/1ps
package vcg_pkg;
  localparam int DEF_POS_W = 8;
  localparam int DEF_NPAT  = 4;
  localparam int DEF_NGRP  = 4;
  localparam int DEF_NTOG  = 4;
  localparam int DEF_REP_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } vcg_state_e;
endpackage

// File: rtl/vcg_rst_sync.sv
`timescale 1ns/1ps
module vcg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vcg_merge.sv
`timescale 1ns/1ps
// Builds the merged toggle list: one entry per (group, slot) pair.
module vcg_merge #(
  parameter int POS_W = vcg_pkg::DEF_POS_W,
  parameter int NPAT  = vcg_pkg::DEF_NPAT,
  parameter int NGRP  = vcg_pkg::DEF_NGRP,
  parameter int NTOG  = vcg_pkg::DEF_NTOG,
  localparam int SEL_W = $clog2(NPAT),
  localparam int CNT_W = $clog2(NTOG + 1),
  localparam int NENT  = NGRP * NTOG
) (
  input  logic [NPAT*NTOG*POS_W-1:0] toggle_bank,
  input  logic [NPAT*CNT_W-1:0]      pat_count,
  input  logic [NGRP*SEL_W-1:0]      grp_sel,
  output logic [NENT*POS_W-1:0]      ent_pos,
  output logic [NENT-1:0]            ent_vld
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [SEL_W-1:0] sel_g;
    logic [CNT_W-1:0] cnt_g;
    assign sel_g = grp_sel[g*SEL_W +: SEL_W];
    assign cnt_g = pat_count[int'(sel_g)*CNT_W +: CNT_W];

    for (genvar t = 0; t < NTOG; t++) begin : g_tog
      localparam int EIDX = g*NTOG + t;
      int base;
      always_comb begin
        base = (int'(sel_g)*NTOG + t) * POS_W;
      end
      assign ent_pos[EIDX*POS_W +: POS_W] = toggle_bank[base +: POS_W];
      // slot t is used when the pattern's count exceeds t (R1)
      assign ent_vld[EIDX] = (cnt_g > CNT_W'(t));
    end
  end
endmodule

// File: rtl/vcg_match.sv
`timescale 1ns/1ps
// Set membership: any valid entry equal to the current position toggles once.
module vcg_match #(
  parameter int POS_W = vcg_pkg::DEF_POS_W,
  parameter int NENT  = vcg_pkg::DEF_NGRP * vcg_pkg::DEF_NTOG
) (
  input  logic [NENT*POS_W-1:0] ent_pos,
  input  logic [NENT-1:0]       ent_vld,
  input  logic [POS_W-1:0]      cur_pos,
  output logic                  hit
);
  logic [NENT-1:0] eq;

  for (genvar i = 0; i < NENT; i++) begin : g_eq
    assign eq[i] = ent_vld[i] && (ent_pos[i*POS_W +: POS_W] == cur_pos);
  end

  // OR reduction: duplicates collapse to one inversion (R4)
  assign hit = |eq;
endmodule

// File: rtl/vcg_seq.sv
`timescale 1ns/1ps
module vcg_seq #(
  parameter int POS_W = vcg_pkg::DEF_POS_W,
  parameter int REP_W = vcg_pkg::DEF_REP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_tick,
  input  logic             line_start,
  input  logic [POS_W-1:0] start_pos,
  input  logic [POS_W-1:0] period_len,
  input  logic [REP_W-1:0] rep_count,
  input  logic             polarity,
  input  logic             hit,
  output logic [POS_W-1:0] cur_pos,
  output logic             lvl,
  output logic             done
);
  import vcg_pkg::*;

  vcg_state_e       st_q, st_d;
  logic [POS_W-1:0] wc_q, wc_d;
  logic [POS_W-1:0] q_q, q_d;
  logic [REP_W-1:0] rp_q, rp_d;
  logic             lv_q, lv_d;
  logic             dn_q, dn_d;
  logic             run_tick, wrap, last, en, base_lvl;

  assign run_tick = pix_tick &&
                    ((st_q == ST_RUN) || ((st_q == ST_WAIT) && (wc_q == start_pos)));
  assign wrap     = (q_q >= period_len);
  assign last     = wrap && (rp_q >= rep_count);
  assign base_lvl = (q_q == '0) ? polarity : lv_q;
  assign en       = line_start || pix_tick || (st_q == ST_IDLE) || (st_q == ST_WAIT);

  always_comb begin
    st_d = st_q;
    wc_d = wc_q;
    q_d  = q_q;
    rp_d = rp_q;
    lv_d = lv_q;
    dn_d = 1'b0;
    if (line_start) begin
      st_d = ST_WAIT;
      wc_d = '0;
      q_d  = '0;
      rp_d = '0;
      lv_d = polarity;
    end else if (run_tick) begin
      lv_d = base_lvl ^ hit;
      if (last) begin
        st_d = ST_TAIL;
        dn_d = 1'b1;
        q_d  = '0;
        rp_d = '0;
      end else if (wrap) begin
        st_d = ST_RUN;
        q_d  = '0;
        rp_d = rp_q + 1'b1;
      end else begin
        st_d = ST_RUN;
        q_d  = q_q + 1'b1;
      end
    end else begin
      case (st_q)
        ST_IDLE: lv_d = polarity;
        ST_WAIT: begin
          lv_d = polarity;
          if (pix_tick) wc_d = wc_q + 1'b1;
        end
        ST_TAIL: begin
          if (pix_tick) begin
            st_d = ST_IDLE;
            lv_d = polarity;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wc_q <= '0;
      q_q  <= '0;
      rp_q <= '0;
      lv_q <= 1'b0;
    end else if (en) begin
      st_q <= st_d;
      wc_q <= wc_d;
      q_q  <= q_d;
      rp_q <= rp_d;
      lv_q <= lv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dn_q <= 1'b0;
    else        dn_q <= dn_d;
  end

  assign cur_pos = q_q;
  assign lvl     = lv_q;
  assign done    = dn_q;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_q |=> !dn_q);
  assert_done_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_q |-> ($past(pix_tick) && !$past(line_start)));
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (!dn_q && (lv_q == $past(polarity))));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (((st_q == ST_RUN) || (st_q == ST_TAIL)) && !pix_tick && !line_start) |=> $stable(lv_q));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !line_start) |=> !dn_q);
endmodule

// File: rtl/vclk_concat_gen.sv
`timescale 1ns/1ps
module vclk_concat_gen #(
  parameter int POS_W = vcg_pkg::DEF_POS_W,
  parameter int NPAT  = vcg_pkg::DEF_NPAT,
  parameter int NGRP  = vcg_pkg::DEF_NGRP,
  parameter int NTOG  = vcg_pkg::DEF_NTOG,
  parameter int REP_W = vcg_pkg::DEF_REP_W,
  localparam int SEL_W = $clog2(NPAT),
  localparam int CNT_W = $clog2(NTOG + 1),
  localparam int NENT  = NGRP * NTOG
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_tick,
  input  logic                      line_start,
  input  logic [NPAT*NTOG*POS_W-1:0] toggle_bank,
  input  logic [NPAT*CNT_W-1:0]     pat_count,
  input  logic [NGRP*SEL_W-1:0]     grp_sel,
  input  logic [POS_W-1:0]          start_pos,
  input  logic                      polarity,
  input  logic [POS_W-1:0]          period_len,
  input  logic [REP_W-1:0]          rep_count,
  output logic                      vout,
  output logic                      done
);
  logic                 rst_n_s;
  logic [NENT*POS_W-1:0] ent_pos;
  logic [NENT-1:0]       ent_vld;
  logic [POS_W-1:0]      cur_pos;
  logic                  hit;

  vcg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vcg_merge #(
    .POS_W (POS_W), .NPAT (NPAT), .NGRP (NGRP), .NTOG (NTOG)
  ) u_merge (
    .toggle_bank (toggle_bank),
    .pat_count   (pat_count),
    .grp_sel     (grp_sel),
    .ent_pos     (ent_pos),
    .ent_vld     (ent_vld)
  );

  vcg_match #(
    .POS_W (POS_W), .NENT (NENT)
  ) u_match (
    .ent_pos (ent_pos),
    .ent_vld (ent_vld),
    .cur_pos (cur_pos),
    .hit     (hit)
  );

  vcg_seq #(
    .POS_W (POS_W), .REP_W (REP_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pix_tick   (pix_tick),
    .line_start (line_start),
    .start_pos  (start_pos),
    .period_len (period_len),
    .rep_count  (rep_count),
    .polarity   (polarity),
    .hit        (hit),
    .cur_pos    (cur_pos),
    .lvl        (vout),
    .done       (done)
  );
endmodule

// File: tb/tb_vclk_concat_gen.sv
`timescale 1ns/1ps
module tb_vclk_concat_gen;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         pix_tick, line_start, polarity;
  logic [127:0] toggle_bank;
  logic [11:0]  pat_count;
  logic [7:0]   grp_sel;
  logic [7:0]   start_pos, period_len;
  logic [3:0]   rep_count;
  logic         vout, done;

  logic [7:0] bank [4][4];
  int         cnt  [4];
  int         sel  [4];
  bit         mark [256];
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int p = 0; p < 4; p++) begin
      pat_count[p*3 +: 3] = 3'(cnt[p]);
      for (int t = 0; t < 4; t++) toggle_bank[(p*4+t)*8 +: 8] = bank[p][t];
    end
    for (int g = 0; g < 4; g++) grp_sel[g*2 +: 2] = 2'(sel[g]);
  end

  vclk_concat_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .line_start(line_start),
    .toggle_bank(toggle_bank), .pat_count(pat_count), .grp_sel(grp_sel),
    .start_pos(start_pos), .polarity(polarity), .period_len(period_len),
    .rep_count(rep_count), .vout(vout), .done(done)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // R1 R3 R4 R5: union of group contributions, positions past the period dropped
  task automatic build_set();
    for (int s = 0; s < 256; s++) mark[s] = 0;
    for (int g = 0; g < 4; g++) begin
      int p = sel[g];
      int n = (cnt[p] > 4) ? 4 : cnt[p];
      for (int t = 0; t < n; t++)
        if (int'(bank[p][t]) <= int'(period_len)) mark[bank[p][t]] = 1;
    end
  endtask

  function automatic int total_ticks();
    return (int'(period_len) + 1) * (int'(rep_count) + 1);
  endfunction

  // expected level after m strobes of the line (R2 R6 R7 R8)
  function automatic logic exp_vout(int m);
    int k = m - 1;
    int j, q, c;
    if (k < int'(start_pos)) return polarity;
    j = k - int'(start_pos);
    if (j >= total_ticks()) return polarity;
    q = j % (int'(period_len) + 1);
    c = 0;
    for (int s = 0; s <= q; s++) if (mark[s]) c++;
    return polarity ^ c[0];
  endfunction

  function automatic logic exp_done(int m);
    return (m - 1 - int'(start_pos)) == (total_ticks() - 1);
  endfunction

  task automatic do_tick();
    @(negedge clk) pix_tick = 1'b1;
    @(negedge clk) pix_tick = 1'b0;
  endtask

  task automatic do_line_start(bit with_tick);
    @(negedge clk) begin line_start = 1'b1; pix_tick = with_tick; end
    @(negedge clk) begin line_start = 1'b0; pix_tick = 1'b0; end
    check("R9 restart level", vout, polarity);
    check("R9 no done on restart", done, 1'b0);
  endtask

  task automatic run_ticks(int from_m, int to_m);
    for (int m = from_m; m <= to_m; m++) begin
      do_tick();
      check("R2/R6/R7 level", vout, exp_vout(m));
      check("R8 done pulse", done, exp_done(m));
      @(negedge clk);
      check("R11/R8 hold between strobes", vout, exp_vout(m));
      check("R8 done one cycle", done, 1'b0);
    end
  endtask

  task automatic run_line();
    build_set();
    do_line_start(1'b0);
    run_ticks(1, int'(start_pos) + total_ticks() + 2);
  endtask

  task automatic set_pat(int p, int a, int b, int c, int d, int n);
    bank[p][0] = 8'(a); bank[p][1] = 8'(b); bank[p][2] = 8'(c); bank[p][3] = 8'(d);
    cnt[p] = n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_tick = 1'b0; line_start = 1'b0; polarity = 1'b1;
    start_pos = 8'd0; period_len = 8'd0; rep_count = 4'd0;
    for (int p = 0; p < 4; p++) set_pat(p, 0, 0, 0, 0, 0);
    for (int g = 0; g < 4; g++) sel[g] = 0;
    repeat (3) @(negedge clk);
    check("R10 reset vout", vout, 1'b0);
    check("R10 reset done", done, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle follows polarity", vout, 1'b1);
    polarity = 1'b0;
    @(negedge clk);
    check("R10 idle follows polarity", vout, 1'b0);

    // 16 distinct toggles across four distinct patterns (R1 R2)
    set_pat(0, 1, 3, 5, 7, 4);
    set_pat(1, 2, 4, 6, 8, 4);
    set_pat(2, 9, 10, 12, 14, 4);
    set_pat(3, 15, 17, 18, 19, 4);
    sel = '{0, 1, 2, 3};
    start_pos = 8'd3; period_len = 8'd20; rep_count = 4'd1;
    for (int pol = 0; pol < 2; pol++) begin
      polarity = pol[0];
      run_line();
    end

    // shared pattern pointers (R3)
    sel = '{0, 1, 1, 1};
    polarity = 1'b1; start_pos = 8'd0; rep_count = 4'd2;
    run_line();
    sel = '{2, 2, 3, 2};
    polarity = 1'b0;
    run_line();

    // duplicate positions, positions past the period, count above 4 (R4 R5 R1)
    set_pat(0, 2, 2, 5, 30, 4);
    set_pat(1, 5, 6, 40, 0, 2);
    set_pat(2, 3, 3, 3, 3, 0);
    set_pat(3, 1, 8, 9, 10, 7);
    sel = '{0, 1, 2, 3};
    period_len = 8'd10; rep_count = 4'd0; start_pos = 8'd2;
    run_line();

    // toggle at position 0 with several repetitions (R7)
    set_pat(0, 0, 4, 99, 99, 2);
    sel = '{0, 0, 0, 0};
    period_len = 8'd5; rep_count = 4'd3; start_pos = 8'd1;
    run_line();

    // single-position waveform (R7 R8)
    set_pat(0, 0, 0, 0, 0, 1);
    period_len = 8'd0; rep_count = 4'd0; start_pos = 8'd0;
    polarity = 1'b1;
    run_line();

    // after the line: idle follows polarity (R10)
    polarity = 1'b0;
    @(negedge clk);
    check("R10 idle after line", vout, 1'b0);

    // line_start coincident with a strobe mid-run (R9)
    set_pat(0, 1, 3, 5, 7, 4);
    set_pat(1, 2, 4, 6, 8, 4);
    sel = '{0, 1, 0, 1};
    period_len = 8'd9; rep_count = 4'd1; start_pos = 8'd2;
    build_set();
    do_line_start(1'b0);
    run_ticks(1, 7);
    do_line_start(1'b1);
    run_ticks(1, int'(start_pos) + total_ticks() + 1);

    // line_start coincident with the strobe that would end the waveform (R9)
    do_line_start(1'b0);
    run_ticks(1, int'(start_pos) + total_ticks() - 1);
    do_line_start(1'b1);
    check("R9 done suppressed", done, 1'b0);
    run_ticks(1, int'(start_pos) + total_ticks() + 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule